// File: doc/BRIEF.md
# Branch Resolve and Fetch Redirect

This block sits in the execute stage of a short in-order RV32 pipeline with optional 16-bit instructions. Each cycle it takes the decoded control-flow class, the branch condition code, the current PC, the two register operands and the immediate. In the same cycle it decides the branch direction and forms the target address. No prediction is involved: direction and target are both settled in the execute stage.

On a jump, or on a conditional branch whose condition holds, the block drives a redirect strobe and the target onto the fetch address phase. It also clears the one-entry slot that holds the instruction fetched behind the branch, including that fetch's error flag. For jumps it supplies the return address and a link write strobe. For every control-flow instruction it reports the cost in cycles: two for anything that redirects and one for a fall-through branch. The cost does not depend on whether the branch points forward or backward.

While a memory-phase stall holds the execute stage, the block issues no redirect and no link write, and the fetch slot keeps its contents.

Top module: `branch_resolve_redirect`

## Requirements
- R1: With class branch (ex_op = 01), the condition code ex_funct3 selects: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. Signed compares use two's-complement order. The codes 010 and 011 never take.
- R2: For a taken branch and for JAL (ex_op = 10), redirect_addr equals ex_pc + ex_imm, modulo 2^32.
- R3: For JALR (ex_op = 11), redirect_addr equals (ex_rs1 + ex_imm) with bit 0 cleared. Bit 1 is kept, and no fault is raised for it.
- R4: A valid jump, or a valid branch whose condition holds, raises redirect in the same cycle that the instruction is presented.
- R5: A branch whose condition fails leaves redirect low and reports a cost of 1.
- R6: cf_cost is 2 for every redirecting instruction, with the same value for forward and backward offsets. It is 0 for class none (ex_op = 00) or when ex_valid is low.
- R7: A valid jump raises link_we with link_wdata = ex_pc + 2 when ex_len16 is set and ex_pc + 4 otherwise. Branches and class none never raise link_we.
- R8: While mem_stall is high, redirect and link_we stay low.
- R9: The fetch slot (slot_valid, slot_err) loads if_valid and if_err at each unstalled edge. It loads zero at an edge where redirect is high, and it holds its value while mem_stall is high.
- R10: After reset, slot_valid and slot_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | An instruction occupies the execute stage |
| ex_op | input | 2 | Class: 00 none, 01 branch, 10 JAL, 11 JALR |
| ex_funct3 | input | 3 | Branch condition code |
| ex_len16 | input | 1 | Instruction is 16 bits long |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| ex_rs1 | input | 32 | First register operand |
| ex_rs2 | input | 32 | Second register operand |
| ex_imm | input | 32 | Sign-extended immediate |
| mem_stall | input | 1 | Memory-phase stall freezing execute |
| if_valid | input | 1 | Fetch data phase returns an instruction |
| if_err | input | 1 | Fetch data phase reports a bus error |
| redirect | output | 1 | Fetch address phase must jump |
| redirect_addr | output | 32 | New fetch address |
| taken | output | 1 | Resolved branch direction |
| cf_cost | output | 2 | Cycle cost of the current instruction |
| link_we | output | 1 | Write return address |
| link_wdata | output | 32 | Return address |
| slot_valid | output | 1 | Younger instruction held for decode |
| slot_err | output | 1 | Fetch error of the held instruction |

## Verification
The assertions check four rules on every cycle. JALR targets are always even. A failed branch never redirects. Every redirect is priced at two cycles, and a stall blocks both redirect and link write. They also check that the fetch slot is empty after a redirect edge and unchanged across a stalled edge. Only the bench's sweeps can show that each condition code picks the right comparison across sign boundaries, that targets and link values follow the arithmetic, and that forward and backward offsets cost the same.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [1:0] {
    CF_NONE   = 2'b00,
    CF_BRANCH = 2'b01,
    CF_JAL    = 2'b10,
    CF_JALR   = 2'b11
  } cf_op_e;

  localparam logic [2:0] CC_EQ  = 3'b000;
  localparam logic [2:0] CC_NE  = 3'b001;
  localparam logic [2:0] CC_LT  = 3'b100;
  localparam logic [2:0] CC_GE  = 3'b101;
  localparam logic [2:0] CC_LTU = 3'b110;
  localparam logic [2:0] CC_GEU = 3'b111;

  localparam logic [1:0] COST_NONE  = 2'd0;
  localparam logic [1:0] COST_FALL  = 2'd1;
  localparam logic [1:0] COST_TAKEN = 2'd2;
endpackage

// File: rtl/brx_compare.sv
module brx_compare
  import brx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [2:0]      cc,
  output logic            cond_true
);
  localparam int MSB = XLEN - 1;

  // One shared subtractor yields both orderings.
  logic [XLEN:0] diff;
  logic          is_eq;
  logic          lt_u;
  logic          lt_s;

  always_comb begin
    diff  = {1'b0, opa} - {1'b0, opb};
    is_eq = (opa == opb);
    lt_u  = diff[XLEN];
    lt_s  = (opa[MSB] ^ opb[MSB]) ? opa[MSB] : diff[XLEN];
  end

  always_comb begin
    case (cc)
      CC_EQ:   cond_true = is_eq;
      CC_NE:   cond_true = !is_eq;
      CC_LT:   cond_true = lt_s;
      CC_GE:   cond_true = !lt_s;
      CC_LTU:  cond_true = lt_u;
      CC_GEU:  cond_true = !lt_u;
      default: cond_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/brx_target.sv
module brx_target
  import brx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cf_op_e          op,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] imm,
  input  logic            len16,
  output logic [XLEN-1:0] tgt,
  output logic [XLEN-1:0] link
);
  localparam logic [XLEN-1:0] STEP_HALF = XLEN'(2);
  localparam logic [XLEN-1:0] STEP_FULL = XLEN'(4);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] sum;

  always_comb begin
    base = (op == CF_JALR) ? rs1 : pc;
    sum  = base + imm;
    if (op == CF_JALR) tgt = {sum[XLEN-1:1], 1'b0};
    else               tgt = sum;
    link = pc + (len16 ? STEP_HALF : STEP_FULL);
  end
endmodule

// File: rtl/brx_redirect_ctrl.sv
module brx_redirect_ctrl
  import brx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ex_valid,
  input  cf_op_e     op,
  input  logic       cond_true,
  input  logic       mem_stall,
  input  logic       if_valid,
  input  logic       if_err,
  output logic       redirect,
  output logic       taken,
  output logic       link_we,
  output logic [1:0] cost,
  output logic       slot_valid,
  output logic       slot_err
);
  logic is_jump;
  logic hit;
  logic slot_en;
  logic slot_valid_d, slot_err_d;
  logic slot_valid_q, slot_err_q;

  always_comb begin
    is_jump  = (op == CF_JAL) || (op == CF_JALR);
    hit      = ex_valid && (is_jump || ((op == CF_BRANCH) && cond_true));
    taken    = hit;
    redirect = hit && !mem_stall;
    link_we  = ex_valid && is_jump && !mem_stall;
    if (!ex_valid || (op == CF_NONE)) cost = COST_NONE;
    else if (hit)                     cost = COST_TAKEN;
    else                              cost = COST_FALL;
  end

  // Next state of the younger-instruction slot.
  always_comb begin
    slot_en = !mem_stall;
    if (redirect) begin
      slot_valid_d = 1'b0;
      slot_err_d   = 1'b0;
    end else begin
      slot_valid_d = if_valid;
      slot_err_d   = if_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_valid_q <= 1'b0;
      slot_err_q   <= 1'b0;
    end else if (slot_en) begin
      slot_valid_q <= slot_valid_d;
      slot_err_q   <= slot_err_d;
    end
  end

  assign slot_valid = slot_valid_q;
  assign slot_err   = slot_err_q;

  AST_SLOT_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!slot_valid_q && !slot_err_q)); // R9
  AST_SLOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |=> ($stable(slot_valid_q) && $stable(slot_err_q))); // R9
endmodule

// File: rtl/branch_resolve_redirect.sv
module branch_resolve_redirect
  import brx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_valid,
  input  logic [1:0]      ex_op,
  input  logic [2:0]      ex_funct3,
  input  logic            ex_len16,
  input  logic [XLEN-1:0] ex_pc,
  input  logic [XLEN-1:0] ex_rs1,
  input  logic [XLEN-1:0] ex_rs2,
  input  logic [XLEN-1:0] ex_imm,
  input  logic            mem_stall,
  input  logic            if_valid,
  input  logic            if_err,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_addr,
  output logic            taken,
  output logic [1:0]      cf_cost,
  output logic            link_we,
  output logic [XLEN-1:0] link_wdata,
  output logic            slot_valid,
  output logic            slot_err
);
  cf_op_e op;
  logic   cond_true;

  assign op = cf_op_e'(ex_op);

  brx_compare #(.XLEN(XLEN)) u_cmp (
    .opa       (ex_rs1),
    .opb       (ex_rs2),
    .cc        (ex_funct3),
    .cond_true (cond_true)
  );

  brx_target #(.XLEN(XLEN)) u_tgt (
    .op    (op),
    .pc    (ex_pc),
    .rs1   (ex_rs1),
    .imm   (ex_imm),
    .len16 (ex_len16),
    .tgt   (redirect_addr),
    .link  (link_wdata)
  );

  brx_redirect_ctrl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_valid   (ex_valid),
    .op         (op),
    .cond_true  (cond_true),
    .mem_stall  (mem_stall),
    .if_valid   (if_valid),
    .if_err     (if_err),
    .redirect   (redirect),
    .taken      (taken),
    .link_we    (link_we),
    .cost       (cf_cost),
    .slot_valid (slot_valid),
    .slot_err   (slot_err)
  );

  AST_JALR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && (op == CF_JALR)) |-> !redirect_addr[0]); // R3
  AST_FAILED_BRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && (op == CF_BRANCH) && !cond_true) |-> (!redirect && cf_cost == COST_FALL)); // R5
  AST_REDIRECT_COSTS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (cf_cost == COST_TAKEN)); // R6
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |-> (!redirect && !link_we)); // R8
endmodule

// File: tb/branch_resolve_redirect_bench.sv
module branch_resolve_redirect_bench;
  localparam int CLK_P = 10;

  logic        clk, rst_n;
  logic        ex_valid, ex_len16, mem_stall, if_valid, if_err;
  logic [1:0]  ex_op;
  logic [2:0]  ex_funct3;
  logic [31:0] ex_pc, ex_rs1, ex_rs2, ex_imm;
  logic        redirect, taken, link_we, slot_valid, slot_err;
  logic [31:0] redirect_addr, link_wdata;
  logic [1:0]  cf_cost;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] vals [6];

  branch_resolve_redirect u_branch_resolve_redirect (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_op(ex_op),
    .ex_funct3(ex_funct3), .ex_len16(ex_len16), .ex_pc(ex_pc),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_imm(ex_imm),
    .mem_stall(mem_stall), .if_valid(if_valid), .if_err(if_err),
    .redirect(redirect), .redirect_addr(redirect_addr), .taken(taken),
    .cf_cost(cf_cost), .link_we(link_we), .link_wdata(link_wdata),
    .slot_valid(slot_valid), .slot_err(slot_err)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_cond(input logic [2:0] cc, input logic [31:0] a, input logic [31:0] b);
    case (cc)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return a < b;
      3'b111:  return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input logic v, input logic [1:0] op, input logic [2:0] cc,
                       input logic l16, input logic [31:0] pc, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] imm, input logic st);
    @(negedge clk);
    ex_valid = v; ex_op = op; ex_funct3 = cc; ex_len16 = l16;
    ex_pc = pc; ex_rs1 = a; ex_rs2 = b; ex_imm = imm; mem_stall = st;
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
    rst_n = 1'b0; ex_valid = 0; ex_op = 0; ex_funct3 = 0; ex_len16 = 0;
    ex_pc = 0; ex_rs1 = 0; ex_rs2 = 0; ex_imm = 0; mem_stall = 0;
    if_valid = 0; if_err = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(slot_valid == 0 && slot_err == 0, "R10 reset slot", {30'd0, slot_valid, slot_err}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // Branch sweep: every condition code, operand pairs, forward and backward offsets
    for (int cc = 0; cc < 8; cc++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          logic [31:0] imm;
          logic [31:0] pc;
          bit t;
          imm = ((i + j) % 2 == 0) ? 32'h0000_0020 : 32'hFFFF_FFC0;
          pc  = 32'h0000_1000 + 32'(i * 6);
          t   = ref_cond(3'(cc), vals[i], vals[j]);
          drive(1, 2'b01, 3'(cc), 0, pc, vals[i], vals[j], imm, 0);
          chk(redirect == t, "R1 branch direction", {31'd0, redirect}, {31'd0, t});
          if (t) begin
            chk(redirect_addr == pc + imm, "R2 branch target", redirect_addr, pc + imm);
            chk(cf_cost == 2'd2, "R6 taken cost", {30'd0, cf_cost}, 32'd2);
          end else
            chk(cf_cost == 2'd1, "R5 fall-through cost", {30'd0, cf_cost}, 32'd1);
          chk(link_we == 0, "R7 no link on branch", {31'd0, link_we}, 32'd0);
        end

    // Jumps: both lengths, offsets with bit 0 and bit 1 set
    for (int l = 0; l < 2; l++)
      for (int k = 0; k < 6; k++) begin
        logic [31:0] pc;
        logic [31:0] imm;
        logic [31:0] want;
        pc  = 32'h0000_2000 + 32'(k * 2);
        imm = vals[k] + 32'h0000_0003;
        drive(1, 2'b10, 3'd0, l[0], pc, vals[5 - k], 32'd0, imm, 0);
        chk(redirect == 1, "R4 JAL redirect", {31'd0, redirect}, 32'd1);
        chk(redirect_addr == pc + imm, "R2 JAL target", redirect_addr, pc + imm);
        chk(cf_cost == 2'd2, "R6 JAL cost", {30'd0, cf_cost}, 32'd2);
        want = pc + ((l == 1) ? 32'd2 : 32'd4);
        chk(link_we == 1 && link_wdata == want, "R7 JAL link", link_wdata, want);
        drive(1, 2'b11, 3'd0, l[0], pc, vals[5 - k], 32'd0, imm, 0);
        want = (vals[5 - k] + imm) & 32'hFFFF_FFFE;
        chk(redirect == 1, "R4 JALR redirect", {31'd0, redirect}, 32'd1);
        chk(redirect_addr == want, "R3 JALR target", redirect_addr, want);
        want = pc + ((l == 1) ? 32'd2 : 32'd4);
        chk(link_we == 1 && link_wdata == want, "R7 JALR link", link_wdata, want);
      end

    // Halfword-aligned JALR target keeps bit 1
    drive(1, 2'b11, 3'd0, 1, 32'h100, 32'h0000_4000, 32'd0, 32'h0000_0002, 0);
    chk(redirect_addr == 32'h4002, "R3 bit1 kept", redirect_addr, 32'h4002);

    // Class none and invalid slot
    drive(1, 2'b00, 3'd0, 0, 32'h300, 32'd1, 32'd1, 32'h10, 0);
    chk(redirect == 0 && cf_cost == 0 && link_we == 0, "R6 none class", {30'd0, cf_cost}, 32'd0);
    drive(0, 2'b10, 3'd0, 0, 32'h300, 32'd1, 32'd1, 32'h10, 0);
    chk(redirect == 0 && cf_cost == 0 && link_we == 0, "R6 invalid jump", {31'd0, redirect}, 32'd0);

    // Stall blocks redirect and link
    drive(1, 2'b10, 3'd0, 0, 32'h400, 32'd0, 32'd0, 32'h40, 1);
    chk(redirect == 0 && link_we == 0, "R8 stalled jump", {31'd0, redirect}, 32'd0);
    drive(1, 2'b01, 3'd0, 0, 32'h400, 32'd7, 32'd7, 32'h40, 1);
    chk(redirect == 0, "R8 stalled taken branch", {31'd0, redirect}, 32'd0);

    // Fetch slot: capture, flush on redirect, hold on stall
    drive(1, 2'b00, 3'd0, 0, 32'h500, 32'd0, 32'd0, 32'd0, 0);
    if_valid = 1; if_err = 1;
    @(posedge clk); #1;
    chk(slot_valid == 1 && slot_err == 1, "R9 capture", {30'd0, slot_valid, slot_err}, 32'd3);
    drive(1, 2'b10, 3'd0, 0, 32'h500, 32'd0, 32'd0, 32'h80, 0);
    if_valid = 1; if_err = 1;
    @(posedge clk); #1;
    chk(slot_valid == 0 && slot_err == 0, "R9 flush on redirect", {30'd0, slot_valid, slot_err}, 32'd0);
    drive(1, 2'b00, 3'd0, 0, 32'h500, 32'd0, 32'd0, 32'd0, 0);
    if_valid = 1; if_err = 0;
    @(posedge clk); #1;
    chk(slot_valid == 1 && slot_err == 0, "R9 capture clean", {30'd0, slot_valid, slot_err}, 32'd2);
    drive(1, 2'b10, 3'd0, 0, 32'h500, 32'd0, 32'd0, 32'h80, 1);
    if_valid = 0; if_err = 1;
    @(posedge clk); #1;
    chk(slot_valid == 1 && slot_err == 0, "R9 hold on stall", {30'd0, slot_valid, slot_err}, 32'd2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule